// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block loads one fixed word into every location of a connection memory without any per-location writes from the host. Software first sets the fill-enable control bit, then raises the trigger bit while presenting a 5-bit pattern. The block latches the pattern and waits for the next frame pulse. It then walks the memory from address 0 upward, writing one location per clock. Each word carries the pattern in its top five bits and zeros in its lower eleven bits.

The trigger bit stays high from the moment it is accepted until the sweep ends, and it doubles as the busy flag. It drops by itself once the last address has been written. When the memory depth does not exceed one frame period in clocks, the wait for the first frame and the sweep together fit inside two frames. Dropping the enable bit at any point stops the fill at once and clears the trigger.

Top module: `cmem_block_init`

## Requirements
- R1: A trigger request (`trig_set` high at a clock edge) is accepted only while `fill_enable` is high. A request made with the enable low leaves `trig_bit` at 0 and causes no writes.
- R2: After a trigger is accepted, no write happens until a frame pulse is sampled. The first write, to address 0, is presented in the cycle after that edge.
- R3: During a sweep `mem_we` is high in consecutive cycles, and `mem_addr` counts up by one per cycle from 0 to DEPTH-1. Every address is written exactly once.
- R4: Every written word holds the latched pattern in bits 15..11 and zeros in bits 10..0.
- R5: The pattern is captured in the cycle the trigger is accepted. Later changes on `pattern_in` do not alter the words of that sweep.
- R6: `trig_bit` rises in the cycle after an accepted trigger. It falls in the cycle after the write to address DEPTH-1, and `mem_we` is low from then on.
- R7: While `fill_enable` is low, `mem_we` is low in that same cycle. If the enable falls during the wait or the sweep, `trig_bit` clears at the next edge and the sweep does not resume when the enable returns.
- R8: A trigger request made while `trig_bit` is high is ignored. The sweep neither restarts nor picks up a new pattern.
- R9: Frame pulses that arrive during a sweep are ignored. The address sequence continues unbroken.
- R10: After reset, `trig_bit` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_enable | input | 1 | Control bit that permits block filling |
| trig_set | input | 1 | Host request that sets the trigger bit |
| frame_pulse | input | 1 | Frame start, one clock wide |
| pattern_in | input | 5 | Pattern for the upper field of each word |
| mem_addr | output | AW | Connection memory write address |
| mem_wdata | output | 16 | Connection memory write data |
| mem_we | output | 1 | Connection memory write enable |
| trig_bit | output | 1 | Trigger bit, high while a fill is pending or running (busy) |

## Verification
Four complete sweeps run with the patterns all-zeros, all-ones, 10101 and 01010. Each sweep changes `pattern_in` right after the trigger. Checking every written word then separates a correctly latched pattern from a live one, catches bit swaps within the field, and catches leaks into the zeroed low field. Directed cases follow. One drops the enable during the wait and another drops it mid-sweep. One raises the trigger with the enable low. One re-triggers during a sweep, and one adds an extra frame pulse mid-sweep. Each of these has its own outcome at the ports: no writes, a cleared trigger bit, or an unbroken address run.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FILL  = 2'd2
    } cmi_state_e;
endpackage

// File: rtl/cmi_ctrl.sv
module cmi_ctrl
    import cmi_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int PAT_W = 5,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_enable,
    input  logic             trig_set,
    input  logic             frame_pulse,
    input  logic [PAT_W-1:0] pattern_in,
    output logic             fill_active,
    output logic [AW-1:0]    fill_addr,
    output logic [PAT_W-1:0] fill_pattern,
    output logic             trig_bit
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    typedef struct packed {
        cmi_state_e       state;
        logic [AW-1:0]    cnt;
        logic [PAT_W-1:0] pat;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_IDLE: begin
                if (fill_enable && trig_set) begin
                    st_d.state = ST_ARMED;
                    st_d.pat   = pattern_in;
                    st_d.cnt   = '0;
                end
            end
            ST_ARMED: begin
                if (!fill_enable) begin
                    st_d.state = ST_IDLE;
                end else if (frame_pulse) begin
                    st_d.state = ST_FILL;
                    st_d.cnt   = '0;
                end
            end
            ST_FILL: begin
                if (!fill_enable || st_q.cnt == LAST_ADDR) begin
                    st_d.state = ST_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt + AW'(1);
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, pat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_active  = (st_q.state == ST_FILL) && fill_enable;
    assign fill_addr    = st_q.cnt;
    assign fill_pattern = st_q.pat;
    assign trig_bit     = (st_q.state != ST_IDLE);

    // R8: a held trigger never relatches the pattern mid-fill
    assert_no_relatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_FILL && $past(st_q.state == ST_FILL)) |-> $stable(st_q.pat));

    // R7: enable low always forces the controller back to idle
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_enable && st_q.state != ST_IDLE) |=> (st_q.state == ST_IDLE));
endmodule

// File: rtl/cmi_word_fmt.sv
module cmi_word_fmt #(
    parameter int WORD_W = 16,
    parameter int PAT_W  = 5
) (
    input  logic [PAT_W-1:0]  pattern,
    output logic [WORD_W-1:0] word
);
    localparam int LOW_W = WORD_W - PAT_W;

    generate
        if (LOW_W > 0) begin : g_split
            assign word = {pattern, {LOW_W{1'b0}}};
        end else begin : g_full
            assign word = pattern[PAT_W-1 -: WORD_W];
        end
    endgenerate
endmodule

// File: rtl/cmem_block_init.sv
module cmem_block_init #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16,
    parameter int PAT_W  = 5,
    parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_enable,
    input  logic              trig_set,
    input  logic              frame_pulse,
    input  logic [PAT_W-1:0]  pattern_in,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              trig_bit
);
    localparam int LOW_W = WORD_W - PAT_W;

    logic [PAT_W-1:0] held_pat;

    cmi_ctrl #(.DEPTH(DEPTH), .PAT_W(PAT_W), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_enable  (fill_enable),
        .trig_set     (trig_set),
        .frame_pulse  (frame_pulse),
        .pattern_in   (pattern_in),
        .fill_active  (mem_we),
        .fill_addr    (mem_addr),
        .fill_pattern (held_pat),
        .trig_bit     (trig_bit)
    );

    cmi_word_fmt #(.WORD_W(WORD_W), .PAT_W(PAT_W)) u_fmt (
        .pattern (held_pat),
        .word    (mem_wdata)
    );

    // frame pulses seen while busy, for the two-frame bound
    logic [1:0] frames_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frames_q <= '0;
        end else if (!trig_bit) begin
            frames_q <= '0;
        end else if (frame_pulse && frames_q != 2'd3) begin
            frames_q <= frames_q + 2'd1;
        end
    end

    assert_we_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (fill_enable && trig_bit));

    assert_low_field_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata[LOW_W-1:0] == '0));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    assert_first_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> (mem_addr == '0));

    assert_trig_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == AW'(DEPTH - 1)) |=> !trig_bit);

    assert_two_frames_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_bit |-> (frames_q <= 2'd2));
endmodule

// File: tb/cmem_block_init_bench.sv
module cmem_block_init_bench;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fill_enable = 1'b0;
    logic          trig_set = 1'b0;
    logic          frame_pulse = 1'b0;
    logic [4:0]    pattern_in = '0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_we;
    logic          trig_bit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cmem_block_init #(.DEPTH(DEPTH)) u_cmem_block_init (
        .clk(clk), .rst_n(rst_n), .fill_enable(fill_enable), .trig_set(trig_set),
        .frame_pulse(frame_pulse), .pattern_in(pattern_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .trig_bit(trig_bit)
    );

    // {pattern at trigger, pattern applied afterwards}
    localparam logic [9:0] VEC [0:3] = '{
        {5'h00, 5'h1F}, {5'h1F, 5'h00}, {5'h15, 5'h0A}, {5'h0A, 5'h15}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic trigger(input logic [4:0] p);
        trig_set = 1'b1;
        pattern_in = p;
        step();
        trig_set = 1'b0;
    endtask

    task automatic frame();
        frame_pulse = 1'b1;
        step();
        frame_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step();
        @(negedge clk);
        chk(trig_bit == 1'b0 && mem_we == 1'b0, "R10 reset", {trig_bit, mem_we}, 0);
        step();
        rst_n = 1'b1;
        fill_enable = 1'b1;
        step();

        for (int v = 0; v < 4; v++) begin
            logic [4:0] p0 = VEC[v][9:5];
            trigger(p0);
            pattern_in = VEC[v][4:0];
            @(negedge clk);
            chk(trig_bit == 1'b1, "R6 trig rises", trig_bit, 1);
            step();
            @(negedge clk);
            chk(mem_we == 1'b0, "R2 no write before frame", mem_we, 0);
            step();
            frame();
            for (int i = 0; i < DEPTH; i++) begin
                @(negedge clk);
                chk(mem_we == 1'b1 && mem_addr == AW'(i), "R3 address run",
                    {mem_we, mem_addr}, {1'b1, AW'(i)});
                chk(mem_wdata == {p0, 11'd0}, "R4 R5 word", mem_wdata, {p0, 11'd0});
                if (v == 2 && i == 4) frame_pulse = 1'b1;      // R9 mid-sweep frame
                if (v == 3 && i == 5) begin                     // R8 re-trigger
                    trig_set = 1'b1;
                    pattern_in = 5'h11;
                end
                step();
                frame_pulse = 1'b0;
                trig_set = 1'b0;
            end
            @(negedge clk);
            chk(trig_bit == 1'b0 && mem_we == 1'b0, "R6 self clear", {trig_bit, mem_we}, 0);
            step();
        end

        // R1: trigger with enable low is ignored
        fill_enable = 1'b0;
        trigger(5'h07);
        frame();
        @(negedge clk);
        chk(trig_bit == 1'b0 && mem_we == 1'b0, "R1 trigger ignored", {trig_bit, mem_we}, 0);
        fill_enable = 1'b1;
        step();

        // R7: enable drops while waiting for a frame
        trigger(5'h03);
        fill_enable = 1'b0;
        step();
        @(negedge clk);
        chk(trig_bit == 1'b0, "R7 abort in wait", trig_bit, 0);
        fill_enable = 1'b1;
        step();
        frame();
        @(negedge clk);
        chk(mem_we == 1'b0, "R7 no write after wait abort", mem_we, 0);
        step();

        // R7: enable drops mid-sweep
        trigger(5'h19);
        frame();
        step();
        step();
        fill_enable = 1'b0;
        @(negedge clk);
        chk(mem_we == 1'b0, "R7 write gated at once", mem_we, 0);
        step();
        @(negedge clk);
        chk(trig_bit == 1'b0, "R7 trig cleared on abort", trig_bit, 0);
        fill_enable = 1'b1;
        step();
        @(negedge clk);
        chk(mem_we == 1'b0 && trig_bit == 1'b0, "R7 no resume", {trig_bit, mem_we}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule